// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes one trap request, either a synchronous exception or an already-selected interrupt, and works out where execution goes next. In the same step it produces the write strobes and data for every control register that changes on handler entry. The caller gives it several inputs:

- the trap code;
- the faulting PC and the fetched instruction word;
- the current privilege level and interrupt-enable bit;
- whether a translation-refill trap is in progress;
- whether the core is already in debug mode;
- the two handler bases, the vector-spacing field and the interrupt vector number.

One cycle later the block presents the new PC. It also presents registered strobe and value groups for four destinations: the normal saved-state, cause and return registers; the refill saved-state and return registers; the bad-address and bad-instruction registers; and the debug cause and return registers.

There are three entry paths. The debug path is taken for a debug breakpoint, and for an interrupt that arrives while debug mode is already active. The refill path is taken for a non-interrupt trap while a refill is in progress. The normal path covers everything else. Each path writes its own set of registers. Every entry clears the privilege level and interrupt enable through the mode-write strobe. The vector spacing is programmable in powers of two. Choosing which interrupt to take, and returning from a handler, are handled elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and in every cycle whose previous cycle had no `req`, `ent_valid`, `norm_we`, `refill_we`, `badv_we`, `badi_we` and `dbg_we` are all 0. A `req` sampled at a clock edge produces `ent_valid`=1 after that edge, with exactly one of `norm_we`, `refill_we`, `dbg_we` set. `ent_valid` is also the strobe that clears the privilege level and interrupt enable.
- R2: The vector spacing is 0 bytes when `vec_space` is 0. Otherwise it is 4 × 2^`vec_space` bytes.
- R3: On the normal path, a non-interrupt trap targets `eentry` + main code × spacing. An interrupt (main code 0) targets `eentry` + (64 + `irq_vec`) × spacing. Addresses wrap modulo 2^PC_W.
- R4: The normal path sets `norm_we`. It carries the main and sub codes to `cause_main`/`cause_sub`, `cur_plv`/`cur_ie` to `save_plv`/`save_ie`, and `fault_pc` to `epc`.
- R5: The refill path applies when `refill_active`=1, the main code is not 0 and the debug path does not apply. It sets `refill_we` and `mode_xlat_off`=1 (direct addressing on, paging off). It saves `cur_plv`/`cur_ie` into `rsave_plv`/`rsave_ie`, outputs `fault_pc`>>2 on `rpc`, and targets `refill_entry`. An interrupt with `refill_active`=1 takes the normal path.
- R6: A debug breakpoint (main code 26) takes the debug path regardless of other inputs. It sets `dbg_we`, `dbg_bp`=1, `dbg_irq`=0 and `dbg_code`=0xC, with `dret`=`fault_pc`, and targets `eentry`+0x480.
- R7: An interrupt (main code 0) with `in_debug`=1 takes the debug path. It sets `dbg_irq`=1, `dbg_bp`=0 and `dbg_code`=0, with `dret`=`fault_pc`, and targets `eentry`+0x480.
- R8: `badv_we` is set, with `badv`=`fault_pc`, for main codes 11 (syscall), 12 (break), 13 (illegal instruction), 14 (privileged instruction), 15 (FP disabled), 16 and 17 (vector units disabled) and 18 (FP exception), on a non-debug path only.
- R9: `badi_we` is set, with `badi`=`fault_insn`, for every non-debug entry except these: main code 0 (interrupt), main code 3 (fetch page invalid), and main code 8 with sub code 0 (fetch address error).
- R10: The debug path asserts none of `norm_we`, `refill_we`, `badv_we`, `badi_we`, and `mode_xlat_off` is 0 on every path other than refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Trap request strobe |
| exc_main | input | 6 | Main trap code |
| exc_sub | input | 9 | Sub trap code |
| fault_pc | input | PC_W | PC of the trapping instruction |
| fault_insn | input | INSN_W | Fetched instruction word |
| cur_plv | input | 2 | Current privilege level |
| cur_ie | input | 1 | Current interrupt enable |
| refill_active | input | 1 | Translation-refill trap in progress |
| in_debug | input | 1 | Core already in debug mode |
| eentry | input | PC_W | General handler base |
| refill_entry | input | PC_W | Refill handler base |
| vec_space | input | SPC_W | Vector-spacing field |
| irq_vec | input | VEC_W | Selected interrupt number |
| ent_valid | output | 1 | New PC valid; mode write clearing privilege and enable |
| ent_pc | output | PC_W | Handler address |
| mode_xlat_off | output | 1 | Set direct addressing, clear paging (refill) |
| norm_we | output | 1 | Normal-path register write strobe |
| cause_main | output | 6 | Main code for the status register |
| cause_sub | output | 9 | Sub code for the status register |
| save_plv | output | 2 | Saved privilege level (normal) |
| save_ie | output | 1 | Saved interrupt enable (normal) |
| epc | output | PC_W | Return address (normal) |
| refill_we | output | 1 | Refill-path register write strobe |
| rsave_plv | output | 2 | Saved privilege level (refill) |
| rsave_ie | output | 1 | Saved interrupt enable (refill) |
| rpc | output | PC_W-2 | Refill return address, word granular |
| badv_we | output | 1 | Bad-address write strobe |
| badv | output | PC_W | Bad-address value |
| badi_we | output | 1 | Bad-instruction write strobe |
| badi | output | INSN_W | Bad-instruction value |
| dbg_we | output | 1 | Debug-path write strobe; also sets debug mode |
| dbg_bp | output | 1 | Debug cause: breakpoint |
| dbg_irq | output | 1 | Debug cause: interrupt in debug mode |
| dbg_code | output | 6 | Debug cause code |
| dret | output | PC_W | Debug return address |

## Verification
The riskiest corner is path precedence. A breakpoint raised during a refill must still go to debug. An interrupt raised during a refill must take the normal path. A design that checks the refill flag first would send these to the wrong handler, or would clobber the refill return register.

The spacing field at 0 must collapse every vector onto the base, and an interrupt must add the offset of 64. A shift off by one, or a missing offset, shows up as a wrong `ent_pc`.

The bad-instruction exclusions depend on the sub code: an address error with sub code 0 is excluded, while sub code 1 is not. A decoder that looks only at the main code would write `badi` on a fetch fault. Debug entries are also checked for stray writes to the normal, bad-address and bad-instruction registers.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    PATH_NORM   = 2'd0,
    PATH_REFILL = 2'd1,
    PATH_DEBUG  = 2'd2
  } entry_path_e;

  localparam logic [5:0] EC_INT       = 6'd0;
  localparam logic [5:0] EC_PG_FETCH  = 6'd3;
  localparam logic [5:0] EC_ADDR      = 6'd8;
  localparam logic [5:0] EC_SYSCALL   = 6'd11;
  localparam logic [5:0] EC_BREAK     = 6'd12;
  localparam logic [5:0] EC_ILLEGAL   = 6'd13;
  localparam logic [5:0] EC_PRIV_INS  = 6'd14;
  localparam logic [5:0] EC_FP_OFF    = 6'd15;
  localparam logic [5:0] EC_V128_OFF  = 6'd16;
  localparam logic [5:0] EC_V256_OFF  = 6'd17;
  localparam logic [5:0] EC_FP_EXC    = 6'd18;
  localparam logic [5:0] EC_DEBUG_BP  = 6'd26;

  localparam int         EXT_IRQ_BASE = 64;
  localparam int         DBG_OFFSET   = 'h480;
  localparam logic [5:0] DBG_BP_CODE  = 6'hC;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [5:0]  exc_main,
  input  logic [8:0]  exc_sub,
  input  logic        refill_active,
  input  logic        in_debug,
  output entry_path_e path,
  output logic        is_intr,
  output logic        want_badv,
  output logic        want_badi,
  output logic        cause_bp,
  output logic        cause_irq
);

  logic to_debug;

  always_comb begin
    is_intr   = (exc_main == EC_INT);
    cause_bp  = (exc_main == EC_DEBUG_BP);
    cause_irq = is_intr && in_debug;
    to_debug  = cause_bp || cause_irq;

    if (to_debug)                       path = PATH_DEBUG;
    else if (refill_active && !is_intr) path = PATH_REFILL;
    else                                path = PATH_NORM;

    case (exc_main)
      EC_SYSCALL, EC_BREAK, EC_ILLEGAL, EC_PRIV_INS,
      EC_FP_OFF, EC_V128_OFF, EC_V256_OFF, EC_FP_EXC: want_badv = !to_debug;
      default:                                        want_badv = 1'b0;
    endcase

    want_badi = !to_debug;
    if (is_intr || exc_main == EC_PG_FETCH ||
        (exc_main == EC_ADDR && exc_sub == 9'd0))
      want_badi = 1'b0;
  end

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_entry_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int VEC_W = 4,
  parameter int SPC_W = 3
) (
  input  entry_path_e      path,
  input  logic             is_intr,
  input  logic [5:0]       exc_main,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [SPC_W-1:0] vec_space,
  input  logic [PC_W-1:0]  eentry,
  input  logic [PC_W-1:0]  refill_entry,
  output logic [PC_W-1:0]  target
);

  localparam int NSP   = 1 << SPC_W;
  localparam int IDX_W = ((VEC_W > 6) ? VEC_W : 6) + 2;

  logic [IDX_W-1:0] slot;
  logic [PC_W-1:0]  cand [NSP];

  assign slot = is_intr ? (IDX_W'(EXT_IRQ_BASE) + IDX_W'(irq_vec))
                        : IDX_W'(exc_main);

  // One candidate offset per spacing setting; setting 0 means no spacing.
  for (genvar g = 0; g < NSP; g++) begin : g_sp
    if (g == 0) begin : g_zero
      assign cand[g] = '0;
    end else begin : g_shift
      assign cand[g] = PC_W'(slot) << (g + 2);
    end
  end

  always_comb begin
    case (path)
      PATH_DEBUG:  target = eentry + PC_W'(DBG_OFFSET);
      PATH_REFILL: target = refill_entry;
      default:     target = eentry + cand[vec_space];
    endcase
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  parameter int VEC_W  = 4,
  parameter int SPC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [5:0]        exc_main,
  input  logic [8:0]        exc_sub,
  input  logic [PC_W-1:0]   fault_pc,
  input  logic [INSN_W-1:0] fault_insn,
  input  logic [1:0]        cur_plv,
  input  logic              cur_ie,
  input  logic              refill_active,
  input  logic              in_debug,
  input  logic [PC_W-1:0]   eentry,
  input  logic [PC_W-1:0]   refill_entry,
  input  logic [SPC_W-1:0]  vec_space,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              ent_valid,
  output logic [PC_W-1:0]   ent_pc,
  output logic              mode_xlat_off,
  output logic              norm_we,
  output logic [5:0]        cause_main,
  output logic [8:0]        cause_sub,
  output logic [1:0]        save_plv,
  output logic              save_ie,
  output logic [PC_W-1:0]   epc,
  output logic              refill_we,
  output logic [1:0]        rsave_plv,
  output logic              rsave_ie,
  output logic [PC_W-3:0]   rpc,
  output logic              badv_we,
  output logic [PC_W-1:0]   badv,
  output logic              badi_we,
  output logic [INSN_W-1:0] badi,
  output logic              dbg_we,
  output logic              dbg_bp,
  output logic              dbg_irq,
  output logic [5:0]        dbg_code,
  output logic [PC_W-1:0]   dret
);

  entry_path_e     path;
  logic            is_intr, want_badv, want_badi, cause_bp, cause_irq;
  logic [PC_W-1:0] target;

  exc_classify u_cls (
    .exc_main      (exc_main),
    .exc_sub       (exc_sub),
    .refill_active (refill_active),
    .in_debug      (in_debug),
    .path          (path),
    .is_intr       (is_intr),
    .want_badv     (want_badv),
    .want_badi     (want_badi),
    .cause_bp      (cause_bp),
    .cause_irq     (cause_irq)
  );

  exc_vec_calc #(.PC_W(PC_W), .VEC_W(VEC_W), .SPC_W(SPC_W)) u_vec (
    .path         (path),
    .is_intr      (is_intr),
    .exc_main     (exc_main),
    .irq_vec      (irq_vec),
    .vec_space    (vec_space),
    .eentry       (eentry),
    .refill_entry (refill_entry),
    .target       (target)
  );

  // Strobes: cleared whenever no request was taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid     <= 1'b0;
      norm_we       <= 1'b0;
      refill_we     <= 1'b0;
      dbg_we        <= 1'b0;
      badv_we       <= 1'b0;
      badi_we       <= 1'b0;
      mode_xlat_off <= 1'b0;
    end else begin
      ent_valid     <= req;
      norm_we       <= req && (path == PATH_NORM);
      refill_we     <= req && (path == PATH_REFILL);
      dbg_we        <= req && (path == PATH_DEBUG);
      badv_we       <= req && want_badv;
      badi_we       <= req && want_badi;
      mode_xlat_off <= req && (path == PATH_REFILL);
    end
  end

  // Data: loaded on each request, held otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_pc     <= '0;
      cause_main <= '0;
      cause_sub  <= '0;
      save_plv   <= '0;
      save_ie    <= 1'b0;
      epc        <= '0;
      rsave_plv  <= '0;
      rsave_ie   <= 1'b0;
      rpc        <= '0;
      badv       <= '0;
      badi       <= '0;
      dbg_bp     <= 1'b0;
      dbg_irq    <= 1'b0;
      dbg_code   <= '0;
      dret       <= '0;
    end else if (req) begin
      ent_pc     <= target;
      cause_main <= exc_main;
      cause_sub  <= exc_sub;
      save_plv   <= cur_plv;
      save_ie    <= cur_ie;
      epc        <= fault_pc;
      rsave_plv  <= cur_plv;
      rsave_ie   <= cur_ie;
      rpc        <= fault_pc[PC_W-1:2];
      badv       <= fault_pc;
      badi       <= fault_insn;
      dbg_bp     <= cause_bp;
      dbg_irq    <= cause_irq && !cause_bp;
      dbg_code   <= cause_bp ? DBG_BP_CODE : 6'd0;
      dret       <= fault_pc;
    end
  end

  AST_ENTRY_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> ent_valid);  // R1
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> $countones({norm_we, refill_we, dbg_we}) == 1);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ent_valid |-> !(norm_we || refill_we || dbg_we || badv_we || badi_we));  // R1
  AST_DEBUG_TARGET: assert property (@(posedge clk) disable iff (rst)
    dbg_we |-> ent_pc == $past(eentry) + PC_W'(DBG_OFFSET));  // R6
  AST_REFILL_RET: assert property (@(posedge clk) disable iff (rst)
    refill_we |-> rpc == $past(fault_pc[PC_W-1:2]) && ent_pc == $past(refill_entry));  // R5
  AST_DEBUG_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
    dbg_we |-> !badv_we && !badi_we && !mode_xlat_off);  // R10
  AST_BP_CODE: assert property (@(posedge clk) disable iff (rst)
    (dbg_we && dbg_bp) |-> dbg_code == 6'hC && !dbg_irq);  // R6
  AST_INTR_NO_BADI: assert property (@(posedge clk) disable iff (rst)
    (norm_we && cause_main == 6'd0) |-> !badi_we && !badv_we);  // R9

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;

  localparam int PC_W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [5:0]  exc_main = '0;
  logic [8:0]  exc_sub = '0;
  logic [31:0] fault_pc = '0, fault_insn = '0, eentry = '0, refill_entry = '0;
  logic [1:0]  cur_plv = '0;
  logic        cur_ie = 1'b0, refill_active = 1'b0, in_debug = 1'b0;
  logic [2:0]  vec_space = '0;
  logic [3:0]  irq_vec = '0;

  logic        ent_valid, mode_xlat_off, norm_we, save_ie, refill_we, rsave_ie;
  logic        badv_we, badi_we, dbg_we, dbg_bp, dbg_irq;
  logic [31:0] ent_pc, epc, badv, badi, dret;
  logic [5:0]  cause_main, dbg_code;
  logic [8:0]  cause_sub;
  logic [1:0]  save_plv, rsave_plv;
  logic [29:0] rpc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .req(req), .exc_main(exc_main), .exc_sub(exc_sub),
    .fault_pc(fault_pc), .fault_insn(fault_insn), .cur_plv(cur_plv), .cur_ie(cur_ie),
    .refill_active(refill_active), .in_debug(in_debug), .eentry(eentry),
    .refill_entry(refill_entry), .vec_space(vec_space), .irq_vec(irq_vec),
    .ent_valid(ent_valid), .ent_pc(ent_pc), .mode_xlat_off(mode_xlat_off),
    .norm_we(norm_we), .cause_main(cause_main), .cause_sub(cause_sub),
    .save_plv(save_plv), .save_ie(save_ie), .epc(epc), .refill_we(refill_we),
    .rsave_plv(rsave_plv), .rsave_ie(rsave_ie), .rpc(rpc), .badv_we(badv_we),
    .badv(badv), .badi_we(badi_we), .badi(badi), .dbg_we(dbg_we), .dbg_bp(dbg_bp),
    .dbg_irq(dbg_irq), .dbg_code(dbg_code), .dret(dret)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] spacing(input logic [2:0] f);
    return (f == 0) ? 32'd0 : 32'd4 * (32'd1 << f);
  endfunction

  function automatic bit badv_code(input logic [5:0] m);
    return m inside {6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18};
  endfunction

  task automatic idle_check();
    chk("R1 idle ent_valid", ent_valid, 0);
    chk("R1 idle strobes", {norm_we, refill_we, dbg_we, badv_we, badi_we}, 0);
  endtask

  task automatic run_one(input logic [5:0] m, input logic [8:0] s, input logic [31:0] pc,
                         input logic [31:0] insn, input logic [1:0] plv, input logic ie,
                         input logic rf, input logic dbg, input logic [31:0] eb,
                         input logic [31:0] rb, input logic [2:0] sp, input logic [3:0] v);
    bit is_int, dp, rp, np;
    logic [31:0] tgt;
    exc_main = m; exc_sub = s; fault_pc = pc; fault_insn = insn; cur_plv = plv;
    cur_ie = ie; refill_active = rf; in_debug = dbg; eentry = eb; refill_entry = rb;
    vec_space = sp; irq_vec = v; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    is_int = (m == 0);
    dp = (m == 26) || (is_int && dbg);
    rp = !dp && rf && !is_int;
    np = !dp && !rp;
    if (dp)      tgt = eb + 32'h480;
    else if (rp) tgt = rb;
    else         tgt = eb + (is_int ? (32'd64 + 32'(v)) : 32'(m)) * spacing(sp);
    chk("R1 ent_valid", ent_valid, 1);
    if (dp) chk("R6 R7 debug target", ent_pc, tgt);
    else if (rp) chk("R5 refill target", ent_pc, tgt);
    else chk("R2 R3 normal target", ent_pc, tgt);
    chk("R4 norm_we", norm_we, np);
    chk("R5 refill_we", refill_we, rp);
    chk("R10 mode_xlat_off", mode_xlat_off, rp);
    chk("R6 dbg_we", dbg_we, dp);
    if (np) begin
      chk("R4 cause", {cause_main, cause_sub}, {m, s});
      chk("R4 save", {save_plv, save_ie}, {plv, ie});
      chk("R4 epc", epc, pc);
    end
    if (rp) begin
      chk("R5 rsave", {rsave_plv, rsave_ie}, {plv, ie});
      chk("R5 rpc", rpc, pc[31:2]);
    end
    if (dp) begin
      chk("R6 R7 dbg_bp", dbg_bp, m == 26);
      chk("R7 dbg_irq", dbg_irq, is_int);
      chk("R6 dbg_code", dbg_code, (m == 26) ? 6'hC : 6'h0);
      chk("R6 dret", dret, pc);
    end
    chk("R8 R10 badv_we", badv_we, !dp && badv_code(m));
    if (badv_we) chk("R8 badv", badv, pc);
    chk("R9 R10 badi_we", badi_we,
        !dp && !(is_int || m == 3 || (m == 8 && s == 0)));
    if (badi_we) chk("R9 badi", badi, insn);
    @(negedge clk);
    idle_check();
  endtask

  initial begin
    logic [5:0] m;
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check();  // R1 reset state
    // Directed corners
    run_one(6'd11, 9'd0, 32'h1000_0040, 32'hdead_beef, 2'd3, 1, 0, 0,
            32'h8000_0000, 32'h9000_0000, 3'd0, 4'd0);              // R2 spacing 0
    run_one(6'd0, 9'd0, 32'h1000_0080, 32'h1111_2222, 2'd1, 1, 0, 0,
            32'h8000_0000, 32'h9000_0000, 3'd1, 4'd5);              // R3 interrupt
    run_one(6'd0, 9'd0, 32'h1000_0084, 32'h0, 2'd2, 0, 1, 0,
            32'h8000_0000, 32'h9000_0000, 3'd7, 4'd15);             // R5 irq during refill
    run_one(6'd1, 9'd0, 32'h2000_0104, 32'h3333_4444, 2'd3, 1, 1, 0,
            32'h8000_0000, 32'h9000_1000, 3'd2, 4'd0);              // R5 refill
    run_one(6'd26, 9'd0, 32'h2000_0200, 32'h5555_6666, 2'd3, 1, 1, 1,
            32'hffff_fc00, 32'h9000_0000, 3'd3, 4'd0);              // R6 bp in refill, wrap
    run_one(6'd0, 9'd0, 32'h2000_0300, 32'h0, 2'd0, 0, 0, 1,
            32'h8000_0000, 32'h9000_0000, 3'd3, 4'd2);              // R7
    run_one(6'd8, 9'd0, 32'h3000_0000, 32'h7777_8888, 2'd0, 0, 0, 0,
            32'h8000_0000, 32'h9000_0000, 3'd4, 4'd0);              // R9 fetch addr err
    run_one(6'd8, 9'd1, 32'h3000_0004, 32'h7777_9999, 2'd0, 0, 0, 0,
            32'h8000_0000, 32'h9000_0000, 3'd4, 4'd0);              // R9 data addr err
    run_one(6'd3, 9'd0, 32'h3000_0008, 32'haaaa_bbbb, 2'd0, 1, 0, 1,
            32'h8000_0000, 32'h9000_0000, 3'd5, 4'd0);              // R9 fetch page
    run_one(6'd18, 9'd1, 32'h3000_000c, 32'hcccc_dddd, 2'd1, 0, 0, 0,
            32'h8000_0000, 32'h9000_0000, 3'd6, 4'd0);              // R8 R4 FP exc
    // Constrained random
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 3))
        0: m = 6'd0;
        1: m = 6'd26;
        2: m = 6'($urandom_range(1, 18));
        default: m = 6'($urandom);
      endcase
      run_one(m, 9'($urandom_range(0, 2)), $urandom, $urandom, 2'($urandom), 1'($urandom),
              ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
              $urandom, $urandom, 3'($urandom), 4'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule